// File: doc/BRIEF.md
# Quat-Stream Receive Lane Framer

This block sits behind the slicer of one receive pair of a multi-pair copper link. Each clock it takes one decoded line symbol: a 2-bit level code plus a flag saying that the line carried no signal in that symbol period. Every non-null symbol stands for two data bits. The framer recovers byte boundaries from this bit stream, delivers the frame bytes of the lane after descrambling, and marks the end of the lane's frame.

To find a byte boundary, the framer waits for one idle byte followed at once by the lane's preamble pattern. It tests this against a sliding window that moves one symbol at a time, so every symbol phase is tried. A lane that carries the first byte of each pair uses four preamble bytes. The other lane uses three preamble bytes followed by the start-of-frame byte. After alignment, the data symbols pass through a self-synchronizing descrambler and are packed into bytes. The frame ends with one byte period of null symbols followed by a control byte. That control byte is not descrambled and is reported on its own port.

After the control byte, extension bytes are counted but not delivered. Any other byte sends the framer back to hunting. A broken null run, or a null that falls inside a byte, is reported as a receive error and also forces a new hunt.

Top module: `qlane_rx_framer`

## Requirements
- R1: Level codes decode to bit pairs as follows: code 3 (+3) gives 10, code 2 (+1) gives 11, code 1 (-1) gives 01 and code 0 (-3) gives 00. The first symbol of a byte carries its two most significant bits.
- R2: With `lane_b_i`=0, the pattern E1h AAh AAh AAh AAh (all 20 symbols non-null) raises `aligned_o` for one cycle. The pulse comes on the edge that takes the last preamble symbol, and `in_frame_o` rises on that same edge.
- R3: With `lane_b_i`=1, the required pattern is E1h AAh AAh AAh ABh. A lane set to one pattern type never aligns on the other type's pattern.
- R4: No alignment happens unless the idle byte E1h sits directly before the preamble bytes and no symbol in the pattern is null.
- R5: The framer descrambles data bits one at a time in arrival order, as out = in ^ s[6] ^ s[5] with s shifting in received bits. Here s[0] is the most recent bit, which makes this the inverse of x^7+x^6+1. The state is cleared on alignment, and `byte_suspect_o` marks only the first byte of each frame.
- R6: Four null symbols that start on a byte boundary, followed by four non-null symbols, end the frame. The raw control byte then appears on `ctrl_o` with a one-cycle `eop_o`, and `in_frame_o` falls.
- R7: `ctrl_o` changes only on an `eop_o` cycle.
- R8: A null run of 1 to 3 symbols followed by a data symbol, a null symbol inside a data byte, or a null inside the control byte gives a one-cycle `rx_err_o` and drops `in_frame_o`.
- R9: After the control byte, each C9h byte increments `ext_cnt_o`, which saturates at its maximum. These bytes raise no `byte_vld_o`, and the count clears on the next alignment.
- R10: Once the frame has ended, the first byte that is not C9h, or a null symbol, returns the framer to hunting. The next frame then aligns as in R2/R3.
- R11: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_b_i | input | 1 | 0: four-preamble lane, 1: three-preamble plus start byte lane |
| sym_null_i | input | 1 | Symbol period carried no signal |
| sym_lvl_i | input | 2 | Level code of the symbol (0..3 = -3,-1,+1,+3) |
| byte_vld_o | output | 1 | One-cycle strobe for a descrambled frame byte |
| byte_o | output | 8 | Descrambled frame byte |
| byte_suspect_o | output | 1 | Byte is the first of its frame and its descrambler history is incomplete |
| in_frame_o | output | 1 | Framer is between alignment and the end-of-data nulls |
| aligned_o | output | 1 | One-cycle alignment pulse |
| eop_o | output | 1 | One-cycle end-of-packet pulse |
| ctrl_o | output | 8 | Last received control byte |
| ext_cnt_o | output | EXT_W | Extension bytes seen since the last alignment |
| rx_err_o | output | 1 | One-cycle broken-null-run error |

## Verification
The bench attacks the pattern boundaries. It sends each lane type's preamble to a lane of the other type, sends preambles with no idle byte in front, and sends zero-length frames. A matcher that ignored the lane type, or that skipped the idle check, would report false alignments. A frame of random bytes checks the descrambler, since wrong taps or the wrong bit order corrupt every byte. A control byte that uses all four levels exposes a swapped decode table. Short null runs and nulls inside a byte must raise an error, where a careless design would either treat them as the end of the frame or let them pass into the data. A long run of extension bytes checks that the counter saturates and that none of these bytes leak out as data.

// File: rtl/qlane_pkg.sv
package qlane_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] IDLE_BYTE = 8'hE1;
  localparam logic [7:0] PRE_BYTE  = 8'hAA;
  localparam logic [7:0] SFD_BYTE  = 8'hAB;
  localparam logic [7:0] EXT_BYTE  = 8'hC9;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_DATA,
    ST_CTRL,
    ST_TAIL
  } fr_state_e;

  // level code 0..3 = -3,-1,+1,+3
  function automatic logic [1:0] quat_bits(input logic [1:0] lvl);
    case (lvl)
      2'd3:    quat_bits = 2'b10;
      2'd2:    quat_bits = 2'b11;
      2'd1:    quat_bits = 2'b01;
      default: quat_bits = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/qlane_sym_dec.sv
module qlane_sym_dec (
  input  logic       null_i,
  input  logic [1:0] lvl_i,
  output logic [1:0] bits_o,
  output logic       ok_o
);
  assign bits_o = null_i ? 2'b00 : qlane_pkg::quat_bits(lvl_i);
  assign ok_o   = !null_i;
endmodule

// File: rtl/qlane_hunt.sv
module qlane_hunt #(
  parameter int unsigned PRE_BYTES = 4,
  parameter int unsigned BPS       = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [BPS-1:0] bits_i,
  input  logic           ok_i,
  input  logic           lane_b_i,
  output logic           hit_o
);
  import qlane_pkg::*;
  localparam int unsigned NBYTES = PRE_BYTES + 1;
  localparam int unsigned W      = NBYTES * BYTE_W;
  localparam int unsigned NS     = W / BPS;

  logic [W-1:0]  win_q, win_n, exp_pat;
  logic [NS-1:0] ok_q, ok_n;

  // window advances one symbol per cycle, so every symbol phase is tested
  assign win_n = {win_q[W-BPS-1:0], bits_i};
  assign ok_n  = {ok_q[NS-2:0], ok_i};

  always_comb begin
    exp_pat = '0;
    exp_pat[W-1 -: BYTE_W] = IDLE_BYTE;
    for (int b = 1; b < NBYTES - 1; b++) exp_pat[W-1-BYTE_W*b -: BYTE_W] = PRE_BYTE;
    exp_pat[BYTE_W-1:0] = lane_b_i ? SFD_BYTE : PRE_BYTE;
  end

  assign hit_o = (&ok_n) && (win_n == exp_pat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      ok_q  <= '0;
    end else begin
      win_q <= win_n;
      ok_q  <= ok_n;
    end
  end
endmodule

// File: rtl/qlane_descr.sv
module qlane_descr #(
  parameter int unsigned LEN   = 7,
  parameter int unsigned TAP_A = 7,
  parameter int unsigned TAP_B = 6,
  parameter int unsigned BPS   = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [BPS-1:0] scr_i,
  output logic [BPS-1:0] plain_o
);
  logic [LEN-1:0] st_q;
  logic [LEN-1:0] st_c [0:BPS];

  assign st_c[0] = st_q;

  // bits handled MSB first, i.e. in line order
  for (genvar i = 0; i < BPS; i++) begin : g_bit
    assign plain_o[BPS-1-i] = scr_i[BPS-1-i] ^ st_c[i][TAP_A-1] ^ st_c[i][TAP_B-1];
    assign st_c[i+1]        = {st_c[i][LEN-2:0], scr_i[BPS-1-i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= '0;
    else if (clr_i) st_q <= '0;
    else if (en_i)  st_q <= st_c[BPS];
  end
endmodule

// File: rtl/qlane_rx_framer.sv
module qlane_rx_framer #(
  parameter int unsigned PRE_BYTES = 4,
  parameter int unsigned EXT_W     = 4,
  parameter int unsigned SCR_LEN   = 7,
  parameter int unsigned SCR_TAP_A = 7,
  parameter int unsigned SCR_TAP_B = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lane_b_i,
  input  logic             sym_null_i,
  input  logic [1:0]       sym_lvl_i,
  output logic             byte_vld_o,
  output logic [7:0]       byte_o,
  output logic             byte_suspect_o,
  output logic             in_frame_o,
  output logic             aligned_o,
  output logic             eop_o,
  output logic [7:0]       ctrl_o,
  output logic [EXT_W-1:0] ext_cnt_o,
  output logic             rx_err_o
);
  import qlane_pkg::*;
  localparam int unsigned BPS   = 2;
  localparam int unsigned SPB   = BYTE_W / BPS;
  localparam int unsigned CNT_W = $clog2(SPB);
  localparam int unsigned NUL_W = $clog2(SPB + 1);
  localparam logic [CNT_W-1:0] LAST_SYM = CNT_W'(SPB - 1);
  localparam logic [NUL_W-1:0] LAST_NUL = NUL_W'(SPB - 1);

  fr_state_e         state_q;
  logic [CNT_W-1:0]  sym_cnt_q;
  logic [NUL_W-1:0]  nul_cnt_q;
  logic [7:0]        asm_q;
  logic              first_q;
  logic              vld_q, susp_q, alg_q, eop_q, err_q;
  logic [7:0]        byte_q, ctrl_q;
  logic [EXT_W-1:0]  ext_q;

  logic [BPS-1:0] sym_bits, plain_bits;
  logic           sym_ok, hit, descr_clr, descr_en;
  logic [7:0]     asm_raw_n, asm_dat_n;

  qlane_sym_dec u_dec (
    .null_i (sym_null_i),
    .lvl_i  (sym_lvl_i),
    .bits_o (sym_bits),
    .ok_o   (sym_ok)
  );

  qlane_hunt #(.PRE_BYTES(PRE_BYTES), .BPS(BPS)) u_hunt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bits_i   (sym_bits),
    .ok_i     (sym_ok),
    .lane_b_i (lane_b_i),
    .hit_o    (hit)
  );

  assign descr_clr = (state_q == ST_HUNT) && hit;
  assign descr_en  = (state_q == ST_DATA) && sym_ok && (nul_cnt_q == '0);

  qlane_descr #(.LEN(SCR_LEN), .TAP_A(SCR_TAP_A), .TAP_B(SCR_TAP_B), .BPS(BPS)) u_descr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (descr_clr),
    .en_i    (descr_en),
    .scr_i   (sym_bits),
    .plain_o (plain_bits)
  );

  assign asm_raw_n = {asm_q[7-BPS:0], sym_bits};
  assign asm_dat_n = {asm_q[7-BPS:0], plain_bits};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      sym_cnt_q <= '0;
      nul_cnt_q <= '0;
      asm_q     <= '0;
      first_q   <= 1'b0;
      vld_q     <= 1'b0;
      susp_q    <= 1'b0;
      alg_q     <= 1'b0;
      eop_q     <= 1'b0;
      err_q     <= 1'b0;
      byte_q    <= '0;
      ctrl_q    <= '0;
      ext_q     <= '0;
    end else begin
      vld_q  <= 1'b0;
      susp_q <= 1'b0;
      alg_q  <= 1'b0;
      eop_q  <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_HUNT: begin
          if (hit) begin
            state_q   <= ST_DATA;
            alg_q     <= 1'b1;
            sym_cnt_q <= '0;
            nul_cnt_q <= '0;
            first_q   <= 1'b1;
            ext_q     <= '0;
          end
        end
        ST_DATA: begin
          if (!sym_ok) begin
            if (sym_cnt_q != '0) begin
              err_q   <= 1'b1;
              state_q <= ST_HUNT;
            end else if (nul_cnt_q == LAST_NUL) begin
              state_q   <= ST_CTRL;
              nul_cnt_q <= '0;
              sym_cnt_q <= '0;
            end else begin
              nul_cnt_q <= nul_cnt_q + 1'b1;
            end
          end else if (nul_cnt_q != '0) begin
            err_q   <= 1'b1;
            state_q <= ST_HUNT;
          end else begin
            asm_q     <= asm_dat_n;
            sym_cnt_q <= sym_cnt_q + 1'b1;
            if (sym_cnt_q == LAST_SYM) begin
              vld_q   <= 1'b1;
              byte_q  <= asm_dat_n;
              susp_q  <= first_q;
              first_q <= 1'b0;
            end
          end
        end
        ST_CTRL: begin
          if (!sym_ok) begin
            err_q   <= 1'b1;
            state_q <= ST_HUNT;
          end else begin
            asm_q     <= asm_raw_n;
            sym_cnt_q <= sym_cnt_q + 1'b1;
            if (sym_cnt_q == LAST_SYM) begin
              ctrl_q  <= asm_raw_n;
              eop_q   <= 1'b1;
              state_q <= ST_TAIL;
            end
          end
        end
        default: begin
          if (!sym_ok) begin
            state_q <= ST_HUNT;
          end else begin
            asm_q     <= asm_raw_n;
            sym_cnt_q <= sym_cnt_q + 1'b1;
            if (sym_cnt_q == LAST_SYM) begin
              if (asm_raw_n == EXT_BYTE) begin
                if (ext_q != '1) ext_q <= ext_q + 1'b1;
              end else begin
                state_q <= ST_HUNT;
              end
            end
          end
        end
      endcase
    end
  end

  assign byte_vld_o     = vld_q;
  assign byte_o         = byte_q;
  assign byte_suspect_o = susp_q;
  assign in_frame_o     = (state_q == ST_DATA);
  assign aligned_o      = alg_q;
  assign eop_o          = eop_q;
  assign ctrl_o         = ctrl_q;
  assign ext_cnt_o      = ext_q;
  assign rx_err_o       = err_q;

  a_r2_align_enters_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |-> in_frame_o);
  a_r5_byte_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> in_frame_o);
  a_r6_eop_leaves_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> (!in_frame_o && !byte_vld_o));
  a_r7_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eop_o |-> $stable(ctrl_o));
  a_r8_err_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |-> (!in_frame_o && !eop_o));
  a_r9_ext_mono: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned_o |-> (ext_cnt_o >= $past(ext_cnt_o)));
endmodule

// File: tb/qlane_rx_framer_tb_top.sv
`timescale 1ns/1ps
module qlane_rx_framer_tb_top;
  localparam int EXT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lane_b = 1'b0;
  logic sym_null = 1'b1;
  logic [1:0] sym_lvl = 2'd0;
  logic byte_vld, byte_susp, in_frame, aligned, eop, rx_err;
  logic [7:0] byte_d, ctrl;
  logic [EXT_W-1:0] ext_cnt;

  always #2 clk = ~clk;

  qlane_rx_framer #(.EXT_W(EXT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lane_b_i(lane_b), .sym_null_i(sym_null),
    .sym_lvl_i(sym_lvl), .byte_vld_o(byte_vld), .byte_o(byte_d),
    .byte_suspect_o(byte_susp), .in_frame_o(in_frame), .aligned_o(aligned),
    .eop_o(eop), .ctrl_o(ctrl), .ext_cnt_o(ext_cnt), .rx_err_o(rx_err)
  );

  int errors = 0, checks = 0;
  int rx_n, align_n, eop_n, err_n;
  logic [7:0] rx_b [256];
  logic       rx_s [256];
  logic [7:0] tx_data [64];
  logic [6:0] tx_s;
  logic [7:0] cap_ctrl;

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input logic [1:0] b);
    case (b)
      2'b10:   enc = 2'd3;
      2'b11:   enc = 2'd2;
      2'b01:   enc = 2'd1;
      default: enc = 2'd0;
    endcase
  endfunction

  task automatic clr_cap();
    rx_n = 0; align_n = 0; eop_n = 0; err_n = 0;
  endtask

  task automatic put_sym(input logic nul, input logic [1:0] lvl);
    @(negedge clk);
    sym_null = nul;
    sym_lvl  = lvl;
    @(posedge clk);
    #1;
    if (byte_vld && rx_n < 256) begin
      rx_b[rx_n] = byte_d;
      rx_s[rx_n] = byte_susp;
      rx_n++;
    end
    if (aligned) align_n++;
    if (eop) begin eop_n++; cap_ctrl = ctrl; end
    if (rx_err) err_n++;
  endtask

  task automatic put_raw(input logic [7:0] b);
    for (int k = 3; k >= 0; k--) put_sym(1'b0, enc(b[2*k +: 2]));
  endtask

  task automatic put_null(input int n);
    for (int k = 0; k < n; k++) put_sym(1'b1, 2'd0);
  endtask

  task automatic put_scr(input logic [7:0] b);
    logic [7:0] sb;
    logic r;
    for (int i = 7; i >= 0; i--) begin
      r = b[i] ^ tx_s[6] ^ tx_s[5];
      tx_s = {tx_s[5:0], r};
      sb[i] = r;
    end
    put_raw(sb);
  endtask

  task automatic put_preamble(input logic lb);
    put_raw(8'hE1); put_raw(8'hE1);
    put_raw(8'hAA); put_raw(8'hAA); put_raw(8'hAA);
    put_raw(lb ? 8'hAB : 8'hAA);
  endtask

  task automatic send_frame(input logic lb, input int n, input logic [7:0] c, input int n_ext);
    int bad, first_bad, susp_bad;
    int exp_ext;
    lane_b = lb;
    clr_cap();
    put_preamble(lb);
    chk(in_frame === 1'b1 && align_n == 1, lb ? "R3" : "R2", "aligned on last preamble symbol", align_n, 1);
    tx_s = '0;
    for (int i = 0; i < n; i++) put_scr(tx_data[i]);
    put_null(4);
    put_raw(c);
    chk(eop_n == 1 && in_frame === 1'b0, "R6", "eop pulse count", eop_n, 1);
    chk(cap_ctrl == c, "R6", "control byte", cap_ctrl, c);
    for (int i = 0; i < n_ext; i++) put_raw(8'hC9);
    put_raw(8'hE1);
    chk(rx_n == n, "R9", "delivered byte count (extensions excluded)", rx_n, n);
    bad = 0; first_bad = -1; susp_bad = 0;
    for (int i = 0; i < n && i < rx_n; i++) begin
      if (rx_b[i] !== tx_data[i]) begin bad++; if (first_bad < 0) first_bad = i; end
      if (rx_s[i] !== (i == 0)) susp_bad++;
    end
    chk(bad == 0, "R5", "descrambled byte mismatches", bad, 0);
    if (first_bad >= 0) chk(1'b0, "R5", "first bad byte value", rx_b[first_bad], tx_data[first_bad]);
    chk(susp_bad == 0, "R5", "suspect flag errors", susp_bad, 0);
    exp_ext = (n_ext > 15) ? 15 : n_ext;
    chk(int'(ext_cnt) == exp_ext, "R9", "extension count", ext_cnt, exp_ext);
    chk(err_n == 0, "R8", "no error in clean frame", err_n, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk({byte_vld, byte_susp, in_frame, aligned, eop, rx_err} == 6'd0 && ctrl == 8'd0 && ext_cnt == '0,
        "R11", "reset outputs", {byte_vld, in_frame, aligned, eop, rx_err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    put_null(3);

    // R1: control byte uses all four levels in a known order
    for (int i = 0; i < 3; i++) tx_data[i] = 8'h11 * (i + 1);
    send_frame(1'b0, 3, 8'hB4, 0);
    chk(ctrl == 8'hB4, "R1", "level decode via control byte", ctrl, 8'hB4);

    // R10: back-to-back frame on lane B, zero length
    send_frame(1'b1, 0, 8'h3C, 2);
    chk(align_n == 1, "R10", "realigned after previous frame", align_n, 1);

    // R9: saturation
    tx_data[0] = 8'h5A;
    send_frame(1'b0, 1, 8'h0F, 17);

    // R3: type-A pattern on lane B, type-B pattern on lane A
    lane_b = 1'b1; clr_cap();
    put_raw(8'hE1); put_raw(8'hAA); put_raw(8'hAA); put_raw(8'hAA); put_raw(8'hAA); put_raw(8'hE1);
    chk(align_n == 0 && rx_n == 0, "R3", "lane B rejects four-preamble pattern", align_n, 0);
    lane_b = 1'b0; clr_cap();
    put_raw(8'hE1); put_raw(8'hAA); put_raw(8'hAA); put_raw(8'hAA); put_raw(8'hAB); put_raw(8'hE1);
    chk(align_n == 0 && in_frame === 1'b0, "R3", "lane A rejects start-byte pattern", align_n, 0);

    // R4: no idle before preamble, and a null inside the pattern
    clr_cap();
    put_raw(8'h00); put_raw(8'hAA); put_raw(8'hAA); put_raw(8'hAA); put_raw(8'hAA); put_raw(8'h00);
    chk(align_n == 0, "R4", "no alignment without idle byte", align_n, 0);
    clr_cap();
    put_raw(8'hE1); put_raw(8'hAA); put_raw(8'hAA); put_null(1);
    put_sym(1'b0, 2'd3); put_sym(1'b0, 2'd3); put_sym(1'b0, 2'd3);
    put_raw(8'hAA); put_raw(8'h00);
    chk(align_n == 0, "R4", "no alignment with null in pattern", align_n, 0);

    // R8: short null run, then mid-byte null, then null in control byte
    lane_b = 1'b0; clr_cap();
    put_preamble(1'b0);
    tx_s = '0; put_scr(8'h12); put_scr(8'h34);
    put_null(2);
    put_sym(1'b0, 2'd2);
    chk(err_n == 1 && in_frame === 1'b0, "R8", "short null run error", err_n, 1);
    chk(eop_n == 0 && rx_n == 2, "R8", "no eop on short run", eop_n, 0);
    chk(ctrl == 8'h0F, "R7", "control byte held after error", ctrl, 8'h0F);
    put_raw(8'h00);
    clr_cap();
    put_preamble(1'b0);
    put_sym(1'b0, 2'd1); put_sym(1'b0, 2'd2); put_null(1);
    chk(err_n == 1 && in_frame === 1'b0, "R8", "mid-byte null error", err_n, 1);
    put_null(3); put_raw(8'h00);
    clr_cap();
    put_preamble(1'b0);
    put_null(4); put_sym(1'b0, 2'd1); put_null(1);
    chk(err_n == 1 && eop_n == 0, "R8", "null inside control byte", err_n, 1);
    put_raw(8'h00);

    // random frames
    for (int f = 0; f < 30; f++) begin
      int n, ne;
      logic lb;
      logic [7:0] c;
      n  = $urandom_range(0, 40);
      ne = $urandom_range(0, 3);
      lb = 1'($urandom_range(0, 1));
      c  = 8'($urandom);
      for (int i = 0; i < n; i++) tx_data[i] = 8'($urandom);
      send_frame(lb, n, c, ne);
      put_null($urandom_range(0, 6));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule